// File: doc/BRIEF.md
# Serial FIFO Error Policy Controller

This block sits between a serial shift engine and the receive and transmit FIFOs that feed it. Each time the engine completes a word, the block decides whether the received word may be pushed into the receive FIFO and which word the engine shifts out next. A receive FIFO that is already full is an overflow. An empty transmit FIFO at the moment a word is needed is an underrun. Each of these is handled under a configurable policy. In the fatal policy the engine is halted. In the tolerant policy the block carries on: it drops the new receive word, or it sends a fill word in place of the missing transmit data.

On the read side, the block reformats words that leave the receive FIFO. The word is cut to the configured word length. The bits above it are then either zero-filled or copies of the sign bit.

Top module: `sfe_policy_ctrl`

## Requirements
- R1: After reset, `halt`, `ovf_flag` and `udr_flag` are 0.
- R2: When `pol_ign_ovf`=0, a word completion (`shift_done`=1 while active) with `rx_full`=1 sets `halt` at the next clock edge.
- R3: When `pol_ign_ovf`=1, a word completion with `rx_full`=1 keeps `rx_push` at 0 and leaves `halt` at 0. When `rx_full`=0, a word completion drives `rx_push`=1 in the same cycle.
- R4: When `pol_ign_udr`=0, a word completion with `tx_empty`=1 sets `halt` at the next clock edge.
- R5: When `pol_ign_udr`=1, `tx_word` shows the fill word and `tx_pop` stays 0 while `tx_empty`=1, and `halt` stays 0. When `tx_empty`=0, `tx_word` equals `tx_fifo_word`, and a completion drives `tx_pop`=1.
- R6: The fill word is `udr_data` when both `pol_udr_src` and `pol_ign_udr` are 1. Otherwise it is the last `rx_word` captured at an active completion, including a word that was dropped on overflow.
- R7: `pol_udr_src` has no effect on `tx_word` while `pol_ign_udr`=0.
- R8: `halt` stays 1 while `enable`=1 and clears one edge after `enable`=0. While halted, `rx_push` and `tx_pop` are 0 and completions raise no flags.
- R9: `ovf_flag` and `udr_flag` are set by any overflow or underrun, whether fatal or not. Each stays set until its clear strobe (`clr_ovf`/`clr_udr`) is sampled high. A new event in the same cycle as the strobe wins over the clear.
- R10: `rd_data` is built from `rx_fifo_rdata` over a word length n = `word_len`, where a value of 0 or a value above 32 means 32. Bits n-1..0 are copied. With `pol_sext`=1 the bits above take the value of bit n-1; with `pol_sext`=0 they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; low clears a halt |
| pol_ign_ovf | input | 1 | Tolerate receive overflow |
| pol_ign_udr | input | 1 | Tolerate transmit underrun |
| pol_udr_src | input | 1 | Fill from `udr_data` instead of last received word |
| pol_sext | input | 1 | Sign-extend read data |
| word_len | input | 6 | Word length, 1..32 (0 or >32 means 32) |
| shift_done | input | 1 | Engine finished a word |
| rx_word | input | 32 | Word just received by the engine |
| rx_full | input | 1 | Receive FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_fifo_word | input | 32 | Head of the transmit FIFO |
| udr_data | input | 32 | Dedicated underrun fill word |
| rx_fifo_rdata | input | 32 | Raw word read from the receive FIFO |
| clr_ovf | input | 1 | Clear strobe for overflow flag |
| clr_udr | input | 1 | Clear strobe for underrun flag |
| halt | output | 1 | Fatal halt request to the engine |
| ovf_flag | output | 1 | Sticky overflow status |
| udr_flag | output | 1 | Sticky underrun status |
| rx_push | output | 1 | Write enable into the receive FIFO |
| tx_pop | output | 1 | Read strobe on the transmit FIFO |
| tx_word | output | 32 | Word the engine sends next |
| rd_data | output | 32 | Reformatted receive read data |

## Verification
Word completions are driven with the FIFO flags in every combination, under both settings of each policy. This shows that the fatal path and the tolerant path part ways on the same event. The fill-source test changes the received word between completions and drops one word on a full FIFO. This tells apart a fill taken from the last captured word and one taken from the last word that was pushed. Sign extension is tried at word lengths 1, 8, 31 and 32 and at the out-of-range code 0, each with the sign bit set and with it clear. This tells a wrong sign-bit index apart from a wrong fill of the upper bits.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef struct packed {
    logic ign_ovf;
    logic ign_udr;
    logic udr_src;
    logic sext;
  } policy_t;
endpackage

// File: rtl/sfe_rx_guard.sv
module sfe_rx_guard #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              shift_done,
  input  logic              rx_full,
  input  logic              ign_ovf,
  input  logic              clr,
  input  logic [DATA_W-1:0] rx_word,
  output logic              rx_push,
  output logic              ovf_evt,
  output logic              ovf_fatal,
  output logic              ovf_flag,
  output logic [DATA_W-1:0] last_rx
);
  logic done_act;
  assign done_act  = shift_done & active;
  assign ovf_evt   = done_act & rx_full;
  assign ovf_fatal = ovf_evt & ~ign_ovf;
  assign rx_push   = done_act & ~rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      last_rx  <= '0;
    end else begin
      if (ovf_evt)  ovf_flag <= 1'b1;
      else if (clr) ovf_flag <= 1'b0;
      if (done_act) last_rx <= rx_word;
    end
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full); // R3
  AST_OVF_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag); // R9
  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R9
endmodule

// File: rtl/sfe_tx_guard.sv
module sfe_tx_guard #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              shift_done,
  input  logic              tx_empty,
  input  logic              ign_udr,
  input  logic              udr_src,
  input  logic              clr,
  input  logic [DATA_W-1:0] udr_data,
  input  logic [DATA_W-1:0] last_rx,
  input  logic [DATA_W-1:0] tx_fifo_word,
  output logic              tx_pop,
  output logic              udr_evt,
  output logic              udr_fatal,
  output logic              udr_flag,
  output logic [DATA_W-1:0] tx_word
);
  logic              use_reg;
  logic [DATA_W-1:0] fill_word;

  assign use_reg   = udr_src & ign_udr;
  assign fill_word = use_reg ? udr_data : last_rx;
  assign tx_word   = tx_empty ? fill_word : tx_fifo_word;
  assign udr_evt   = shift_done & active & tx_empty;
  assign udr_fatal = udr_evt & ~ign_udr;
  assign tx_pop    = shift_done & active & ~tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       udr_flag <= 1'b0;
    else if (udr_evt) udr_flag <= 1'b1;
    else if (clr)     udr_flag <= 1'b0;
  end

  AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R5
  AST_UDR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_flag && !clr) |=> udr_flag); // R9
endmodule

// File: rtl/sfe_rd_extend.sv
module sfe_rd_extend #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [LEN_W-1:0]  len,
  input  logic              sext,
  output logic [DATA_W-1:0] dout
);
  function automatic logic [DATA_W-1:0] extend_word(
    input logic [DATA_W-1:0] w, input logic [LEN_W-1:0] l, input logic s);
    int   n;
    logic sb;
    logic [DATA_W-1:0] r;
    n  = (l == '0 || int'(l) > DATA_W) ? DATA_W : int'(l);
    sb = s & w[n-1];
    for (int i = 0; i < DATA_W; i++)
      r[i] = (i < n) ? w[i] : sb;
    return r;
  endfunction

  assign dout = extend_word(raw, len, sext);

  always_comb begin
    if (!sext && len == LEN_W'(1))
      AST_ZERO_FILL_LEN1: assert (dout[DATA_W-1:1] == '0); // R10
  end
endmodule

// File: rtl/sfe_policy_ctrl.sv
module sfe_policy_ctrl #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pol_ign_ovf,
  input  logic              pol_ign_udr,
  input  logic              pol_udr_src,
  input  logic              pol_sext,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              shift_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_fifo_word,
  input  logic [DATA_W-1:0] udr_data,
  input  logic [DATA_W-1:0] rx_fifo_rdata,
  input  logic              clr_ovf,
  input  logic              clr_udr,
  output logic              halt,
  output logic              ovf_flag,
  output logic              udr_flag,
  output logic              rx_push,
  output logic              tx_pop,
  output logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] rd_data
);
  import sfe_pkg::*;

  policy_t           pol;
  logic              active;
  logic              ovf_evt, ovf_fatal, udr_evt, udr_fatal;
  logic [DATA_W-1:0] last_rx;

  assign pol    = '{ign_ovf: pol_ign_ovf, ign_udr: pol_ign_udr,
                    udr_src: pol_udr_src, sext: pol_sext};
  assign active = enable & ~halt;

  sfe_rx_guard #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .shift_done(shift_done),
    .rx_full(rx_full), .ign_ovf(pol.ign_ovf), .clr(clr_ovf), .rx_word(rx_word),
    .rx_push(rx_push), .ovf_evt(ovf_evt), .ovf_fatal(ovf_fatal),
    .ovf_flag(ovf_flag), .last_rx(last_rx));

  sfe_tx_guard #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .shift_done(shift_done),
    .tx_empty(tx_empty), .ign_udr(pol.ign_udr), .udr_src(pol.udr_src),
    .clr(clr_udr), .udr_data(udr_data), .last_rx(last_rx),
    .tx_fifo_word(tx_fifo_word), .tx_pop(tx_pop), .udr_evt(udr_evt),
    .udr_fatal(udr_fatal), .udr_flag(udr_flag), .tx_word(tx_word));

  sfe_rd_extend #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rd (
    .raw(rx_fifo_rdata), .len(word_len), .sext(pol.sext), .dout(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      halt <= 1'b0;
    else if (!enable)                halt <= 1'b0;
    else if (ovf_fatal || udr_fatal) halt <= 1'b1;
  end

  AST_FATAL_OVF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pol_ign_ovf && enable) |=> halt); // R2
  AST_TOLERATED_OVF_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && enable && pol_ign_ovf && !udr_fatal) |=> !halt); // R3
  AST_FATAL_UDR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_evt && !pol_ign_udr && enable) |=> halt); // R4
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && enable) |=> halt); // R8
  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !halt); // R8
  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!rx_push && !tx_pop)); // R8
endmodule

// File: tb/tb_sfe_policy_ctrl.sv
`timescale 1ns/1ps
module tb_sfe_policy_ctrl;
  logic        clk = 0, rst_n = 0, enable = 0;
  logic        pol_ign_ovf = 0, pol_ign_udr = 0, pol_udr_src = 0, pol_sext = 0;
  logic [5:0]  word_len = 0;
  logic        shift_done = 0, rx_full = 0, tx_empty = 0, clr_ovf = 0, clr_udr = 0;
  logic [31:0] rx_word = 0, tx_fifo_word = 0, udr_data = 0, rx_fifo_rdata = 0;
  logic        halt, ovf_flag, udr_flag, rx_push, tx_pop;
  logic [31:0] tx_word, rd_data;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  sfe_policy_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic setup(); @(negedge clk); endtask

  task automatic restart();
    setup(); enable = 0; shift_done = 0; clr_ovf = 1; clr_udr = 1;
    tick(); setup(); clr_ovf = 0; clr_udr = 0; enable = 1;
  endtask

  task automatic t_reset();
    chk("R1 halt", halt, 0); chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 udr_flag", udr_flag, 0);
  endtask

  task automatic t_fatal_ovf();
    restart(); pol_ign_ovf = 0; rx_full = 1; tx_empty = 0; shift_done = 1;
    #1 chk("R2 push blocked", rx_push, 0);
    tick(); chk("R2 halt", halt, 1); chk("R9 ovf flag set", ovf_flag, 1);
    setup(); shift_done = 1; rx_full = 0; #1;
    chk("R8 no push halted", rx_push, 0); chk("R8 no pop halted", tx_pop, 0);
    tick(); chk("R8 halt holds", halt, 1);
    setup(); shift_done = 0; enable = 0; tick(); chk("R8 halt released", halt, 0);
  endtask

  task automatic t_ignore_ovf();
    restart(); pol_ign_ovf = 1; rx_full = 1; tx_empty = 0; shift_done = 1; #1;
    chk("R3 drop on full", rx_push, 0);
    tick(); chk("R3 no halt", halt, 0);
    setup(); rx_full = 0; #1; chk("R3 push not full", rx_push, 1);
    setup(); shift_done = 0;
  endtask

  task automatic t_fatal_udr();
    restart(); pol_ign_udr = 0; rx_full = 0; tx_empty = 1; shift_done = 1; #1;
    chk("R4 no pop", tx_pop, 0);
    tick(); chk("R4 halt", halt, 1); chk("R9 udr flag set", udr_flag, 1);
    setup(); shift_done = 0; enable = 0; tick();
  endtask

  task automatic t_fill();
    restart(); pol_ign_udr = 1; pol_udr_src = 0; pol_ign_ovf = 1;
    tx_empty = 0; tx_fifo_word = 32'h1111_2222; rx_full = 0;
    rx_word = 32'hAAAA_0001; shift_done = 1; #1;
    chk("R5 fifo word", tx_word, 32'h1111_2222); chk("R5 pop", tx_pop, 1);
    tick(); setup(); shift_done = 0; tx_empty = 1; #1;
    chk("R6 fill last rx", tx_word, 32'hAAAA_0001);
    rx_full = 1; rx_word = 32'hBBBB_0002; shift_done = 1; #1;
    chk("R5 no pop empty", tx_pop, 0);
    tick(); chk("R5 no halt", halt, 0);
    setup(); shift_done = 0; #1;
    chk("R6 fill dropped word", tx_word, 32'hBBBB_0002);
    udr_data = 32'hC0DE_0003; pol_udr_src = 1; #1;
    chk("R6 fill register", tx_word, 32'hC0DE_0003);
    pol_ign_udr = 0; #1;
    chk("R7 src ignored", tx_word, 32'hBBBB_0002);
    pol_ign_udr = 1; rx_full = 0; tx_empty = 0;
  endtask

  task automatic t_flags();
    restart(); pol_ign_ovf = 1; pol_ign_udr = 1; rx_full = 1; tx_empty = 1;
    shift_done = 1; tick(); setup(); shift_done = 0; tick(); tick();
    chk("R9 ovf sticky", ovf_flag, 1); chk("R9 udr sticky", udr_flag, 1);
    setup(); clr_ovf = 1; tick(); setup(); clr_ovf = 0;
    chk("R9 ovf cleared", ovf_flag, 0); chk("R9 udr kept", udr_flag, 1);
    clr_udr = 1; shift_done = 1; tick(); setup(); clr_udr = 0; shift_done = 0;
    chk("R9 set beats clear", udr_flag, 1);
    rx_full = 0; tx_empty = 0;
  endtask

  function automatic logic [31:0] model_ext(logic [31:0] w, int l, bit s);
    int n = (l == 0 || l > 32) ? 32 : l;
    logic [31:0] m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    logic [31:0] v = w & m;
    if (s && ((w >> (n - 1)) & 1)) v = v | ~m;
    return v;
  endfunction

  task automatic t_sext();
    int lens[5] = '{1, 8, 31, 32, 0};
    logic [31:0] pats[2] = '{32'h4000_00F5, 32'hB5A5_0F7A};
    foreach (lens[i]) foreach (pats[j]) for (int s = 0; s < 2; s++) begin
      setup(); word_len = 6'(lens[i]); rx_fifo_rdata = pats[j]; pol_sext = s[0]; #1;
      chk("R10 extend", rd_data, model_ext(pats[j], lens[i], s[0]));
    end
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1 t_reset();
    repeat (2) tick();
    rst_n = 1;
    t_reset();
    t_fatal_ovf();
    t_ignore_ovf();
    t_fatal_udr();
    t_fill();
    t_flags();
    t_sext();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule